// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt request lines, records rising edges in a pending register, and drives a single request line to the processor. The request line rises only when the best unmasked pending input outranks every input already being serviced. Input 0 has the highest priority and input 7 the lowest. The processor answers with a one-cycle acknowledge pulse. One cycle later the block presents an 8-bit vector, formed from a programmable base and the input index, and moves the winning input from pending to in-service.

Software reaches the block through two byte addresses. Address 0 carries commands and address 1 carries data. A command byte with bit 4 set starts a configuration sequence, and the data writes that follow supply the vector base, an optional cascade word and an optional mode word. After that sequence, data writes load the mask. Command writes also issue specific end-of-interrupt commands and choose whether command-port reads return the pending or the in-service register. If a request disappears before it is acknowledged, the acknowledge still receives a vector, namely that of input 7, and no in-service bit is set.

Top module: `pic8_core`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service registers read 0x00, command-port reads return the pending register, and int_out is low.
- R2: A command write with bit 4 set starts configuration. It clears the pending register, the in-service register and the mask (mask becomes 0x00), and it resets the read select to the pending register. The next data write is the vector base.
- R3: When ICW1 bit 1 is 0, the data write after the base is the cascade word. That word is stored and driven on cascade_cfg, and has no other effect.
- R4: A low-to-high transition of a synchronised input sets its pending bit. The bit stays set only while the input stays high, so an input that falls before the acknowledge clears its pending bit.
- R5: Outside configuration, a data write loads the mask (1 masks the input) and a data-port read returns it. A masked input is still recorded as pending but does not raise int_out.
- R6: int_out is high only when the lowest-numbered unmasked pending input has a smaller index than every in-service input.
- R7: An inta pulse while int_out is high sets the winner's in-service bit and clears its pending bit. In the next cycle, vec_valid is high for exactly one cycle with vec_out = {base[7:3], index}.
- R8: A command byte 0b01100nnn clears in-service bit nnn and no other bit.
- R9: Command byte 0x0A selects the pending register and 0x0B selects the in-service register for later command-port reads. The selection persists until it is changed.
- R10: When mode-word bit 1 is 1 (automatic end of interrupt), an acknowledge leaves no in-service bit set.
- R11: An inta pulse while int_out is low yields vec_out = {base[7:3], 3'b111}, whether or not input 7 is masked, and leaves the in-service register unchanged.
- R12: When ICW1 bit 1 is 1, the cascade word is skipped. When ICW1 bit 0 is 0, the mode word is skipped and normal end of interrupt applies. The data write after the last configuration word loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the mask on the data port, the pending or in-service register on the command port |
| irq_in | input | 8 | Asynchronous request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| vec_valid | output | 1 | High for one cycle after an acknowledge |
| vec_out | output | 8 | Vector delivered with vec_valid |
| cascade_cfg | output | 8 | Stored cascade configuration word |

## Verification
The resolver is tried with several input patterns. A lone request checks the vector arithmetic. A later request of lower priority must stay blocked behind an in-service bit, while one of higher priority must nest above it. Two requests raised together are served in index order, so an inverted priority encoder would be caught. A masked request must stay pending but silent, and a request that pulses and drops must produce the input-7 vector. Three configuration variants (full, single without cascade word, single without mode word) check that the sequencer counts its words correctly and that auto and normal end of interrupt are both honoured.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int NLINES = 8;
  localparam int IDXW   = $clog2(NLINES);

  typedef enum logic [1:0] {CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE} cfg_state_e;

  typedef struct packed {
    logic            valid;
    logic [IDXW-1:0] idx;
  } pick_t;

  // Lowest-numbered set bit wins (input 0 is highest priority).
  function automatic pick_t lowest_set(input logic [NLINES-1:0] v);
    pick_t p;
    p = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.valid = 1'b1;
        p.idx   = IDXW'(i);
      end
    end
    return p;
  endfunction

  function automatic logic [NLINES-1:0] bit_of(input logic [IDXW-1:0] idx);
    return NLINES'(1) << idx;
  endfunction

  // Vector: upper bits from the base, lower bits from the input index.
  function automatic logic [7:0] make_vector(input logic [7:0] base, input logic [IDXW-1:0] idx);
    return {base[7:IDXW], idx};
  endfunction
endpackage

// File: rtl/pic_cfg.sv
`timescale 1ns/1ps
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [NLINES-1:0] mask,
  output logic [7:0]        base,
  output logic [7:0]        casc_word,
  output logic              aeoi,
  output logic              rsel_isr,
  output logic              init_clr,
  output logic              eoi_valid,
  output logic [IDXW-1:0]   eoi_idx
);
  cfg_state_e state;
  logic need_casc, need_mode;
  logic cmd_wr, data_wr, ocw3_sel;

  assign cmd_wr    = wr_en & ~addr;
  assign data_wr   = wr_en & addr;
  assign init_clr  = cmd_wr & wdata[4];
  assign ocw3_sel  = cmd_wr & ~wdata[4] & wdata[3] & wdata[1];
  assign eoi_valid = cmd_wr & ~wdata[4] & ~wdata[3] & (wdata[7:5] == 3'b011);
  assign eoi_idx   = wdata[IDXW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CFG_RUN;
      mask      <= '1;
      base      <= '0;
      casc_word <= '0;
      aeoi      <= 1'b0;
      rsel_isr  <= 1'b0;
      need_casc <= 1'b0;
      need_mode <= 1'b0;
    end else if (init_clr) begin
      state     <= CFG_BASE;
      mask      <= '0;
      aeoi      <= 1'b0;
      rsel_isr  <= 1'b0;
      need_casc <= ~wdata[1];
      need_mode <= wdata[0];
    end else if (ocw3_sel) begin
      rsel_isr <= wdata[0];
    end else if (data_wr) begin
      case (state)
        CFG_RUN:  mask <= wdata;
        CFG_BASE: begin
          base  <= wdata;
          state <= need_casc ? CFG_CASC : (need_mode ? CFG_MODE : CFG_RUN);
        end
        CFG_CASC: begin
          casc_word <= wdata;
          state     <= need_mode ? CFG_MODE : CFG_RUN;
        end
        default: begin
          aeoi  <= wdata[1];
          state <= CFG_RUN;
        end
      endcase
    end
  end

  // R5: an operational data write lands in the mask
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && state == CFG_RUN) |=> (mask == $past(wdata)));
  // R2: start of configuration empties the mask and awaits the base
  a_r2_init_start: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (mask == '0 && state == CFG_BASE && !rsel_isr));
  // R12: a data write in the base state never leaves the sequencer there
  a_r12_base_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr && state == CFG_BASE) |=> (state != CFG_BASE));
endmodule

// File: rtl/pic_irr.sv
`timescale 1ns/1ps
module pic_irr
  import pic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              clr_all,
  input  logic [NLINES-1:0] ack_clr,
  output logic [NLINES-1:0] irr
);
  logic [NLINES-1:0] chain [SYNC_STAGES];
  logic [NLINES-1:0] level, level_d, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= '0;
      level_d <= '0;
      irr     <= '0;
    end else begin
      chain[0] <= irq_in;
      for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
      level_d <= level;
      irr     <= clr_all ? '0 : ((irr | rise) & level & ~ack_clr);
    end
  end

  assign level = chain[SYNC_STAGES-1];
  assign rise  = level & ~level_d;

  // R4: an edge that is not being cleared becomes pending
  a_r4_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> (($past(rise & ~ack_clr) & ~irr) == '0));
  // R4: a low input never holds a pending bit
  a_r4_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(level)) == '0));
endmodule

// File: rtl/pic_arb.sv
`timescale 1ns/1ps
module pic_arb
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] mask,
  input  logic [7:0]        base,
  input  logic              aeoi,
  input  logic              inta,
  input  logic              init_clr,
  input  logic              eoi_valid,
  input  logic [IDXW-1:0]   eoi_idx,
  output logic [NLINES-1:0] isr,
  output logic              int_req,
  output logic [NLINES-1:0] ack_clr,
  output logic              vec_valid,
  output logic [7:0]        vec_out
);
  pick_t req, svc;
  logic grant;
  logic [NLINES-1:0] isr_set, isr_clr;

  assign req     = lowest_set(irr & ~mask);
  assign svc     = lowest_set(isr);
  assign int_req = req.valid && (!svc.valid || (req.idx < svc.idx));
  assign grant   = inta & int_req;
  assign ack_clr = grant ? bit_of(req.idx) : '0;
  assign isr_set = (grant && !aeoi) ? bit_of(req.idx) : '0;
  assign isr_clr = eoi_valid ? bit_of(eoi_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      isr       <= init_clr ? '0 : ((isr | isr_set) & ~isr_clr);
      vec_valid <= inta;
      if (inta)
        vec_out <= grant ? make_vector(base, req.idx) : make_vector(base, IDXW'(NLINES - 1));
    end
  end

  // R6: a request is raised only for an unmasked pending input
  a_r6_int_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~mask) != '0));
  // R7: one vector strobe per acknowledge pulse
  a_r7_vec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);
  a_r7_vec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> !vec_valid);
  // R7: a granted input enters service in normal mode
  a_r7_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !aeoi && !init_clr && !eoi_valid) |=> isr[$past(req.idx)]);
  // R8: a specific EOI retires its bit
  a_r8_eoi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !grant) |=> !isr[$past(eoi_idx)]);
  // R10: automatic EOI never adds an in-service bit
  a_r10_aeoi: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi) |=> ((isr & ~$past(isr)) == '0));
  // R11: acknowledge without a request gives the lowest-priority vector
  a_r11_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_req && !eoi_valid && !init_clr) |=>
      (vec_out[IDXW-1:0] == '1 && isr == $past(isr)));
endmodule

// File: rtl/pic8_core.sv
`timescale 1ns/1ps
module pic8_core
  import pic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  output logic [7:0] cascade_cfg
);
  logic [NLINES-1:0] mask, irr, isr, ack_clr;
  logic [7:0]        base;
  logic              aeoi, rsel_isr, init_clr, eoi_valid;
  logic [IDXW-1:0]   eoi_idx;

  pic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mask(mask), .base(base), .casc_word(cascade_cfg), .aeoi(aeoi),
    .rsel_isr(rsel_isr), .init_clr(init_clr), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx)
  );

  pic_irr #(.SYNC_STAGES(SYNC_STAGES)) u_irr (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_all(init_clr),
    .ack_clr(ack_clr), .irr(irr)
  );

  pic_arb u_arb (
    .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .base(base), .aeoi(aeoi),
    .inta(inta), .init_clr(init_clr), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
    .isr(isr), .int_req(int_out), .ack_clr(ack_clr),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  assign bus_rdata = bus_addr ? mask : (rsel_isr ? isr : irr);

  // R9: command-port reads follow the select
  a_r9_read_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_addr && !rsel_isr) |-> (bus_rdata == irr));
endmodule

// File: tb/test_pic8_core.sv
`timescale 1ns/1ps
module test_pic8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic [7:0] cascade_cfg;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pic8_core i_pic8_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .int_out(int_out), .inta(inta), .vec_valid(vec_valid), .vec_out(vec_out),
    .cascade_cfg(cascade_cfg)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Driver: pushes the expected vector, then pulses the acknowledge
  task automatic ack(input string tag, input logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops and compares on each vector strobe
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected vector", vec_out, 8'hxx);
      end else begin
        check(tag_q.pop_front(), vec_out, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_test();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(1'b1, r); check("R1 mask reset", r, 8'hFF);
    rd(1'b0, r); check("R1 pending reset", r, 8'h00);
    check("R1 int_out reset", {7'b0, int_out}, 8'h00);

    // full configuration: cascaded, mode word present, normal EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, r); check("R2 mask cleared by init", r, 8'h00);
    check("R3 cascade word stored", cascade_cfg, 8'h04);

    // lone request
    irq_in[3] = 1'b1; settle();
    check("R4 edge raises int_out", {7'b0, int_out}, 8'h01);
    rd(1'b0, r); check("R9 pending read", r, 8'h08);
    ack("R7 vector input 3", 8'h23);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R9 in-service read", r, 8'h08);
    rd(1'b0, r); check("R9 select persists", r, 8'h08);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); check("R7 pending cleared on ack", r, 8'h00);
    irq_in[3] = 1'b0;

    // nesting against an in-service input
    irq_in[5] = 1'b1; settle();
    check("R6 lower priority blocked", {7'b0, int_out}, 8'h00);
    irq_in[1] = 1'b1; settle();
    check("R6 higher priority nests", {7'b0, int_out}, 8'h01);
    ack("R6 vector input 1", 8'h21);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R7 two in service", r, 8'h0A);
    wr(1'b0, 8'h61);
    rd(1'b0, r); check("R8 specific EOI input 1", r, 8'h08);
    wr(1'b0, 8'h63);
    rd(1'b0, r); check("R8 specific EOI input 3", r, 8'h00);
    @(negedge clk);
    check("R6 pending 5 released", {7'b0, int_out}, 8'h01);
    ack("R6 vector input 5", 8'h25);
    wr(1'b0, 8'h65);
    irq_in = '0; settle();

    // mask
    wr(1'b1, 8'h04);
    irq_in[2] = 1'b1; settle();
    check("R5 masked input silent", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); check("R5 masked input still pending", r, 8'h04);
    rd(1'b1, r); check("R5 mask readback", r, 8'h04);
    wr(1'b1, 8'h00); @(negedge clk);
    check("R5 unmask raises int_out", {7'b0, int_out}, 8'h01);
    ack("R7 vector input 2", 8'h22);
    wr(1'b0, 8'h62);
    irq_in = '0; settle();

    // request that drops before acknowledge
    irq_in[6] = 1'b1; settle();
    irq_in[6] = 1'b0; settle();
    check("R4 dropped request idle", {7'b0, int_out}, 8'h00);
    rd(1'b0, r); check("R4 dropped request not pending", r, 8'h00);
    ack("R11 spurious vector", 8'h27);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R11 no in-service bit", r, 8'h00);
    wr(1'b1, 8'hFF);
    ack("R11 spurious with input 7 masked", 8'h27);
    wr(1'b1, 8'h00);

    // simultaneous requests
    irq_in[4] = 1'b1; irq_in[6] = 1'b1; settle();
    ack("R6 simultaneous first 4", 8'h24);
    check("R6 input 6 blocked by 4", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h64); @(negedge clk);
    ack("R6 simultaneous then 6", 8'h26);
    wr(1'b0, 8'h66);
    irq_in = '0; settle();

    // single, mode word with automatic EOI
    wr(1'b0, 8'h13); wr(1'b1, 8'h48); wr(1'b1, 8'h03);
    check("R12 cascade word skipped", cascade_cfg, 8'h04);
    irq_in[0] = 1'b1; settle();
    ack("R10 vector under auto EOI", 8'h48);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R10 no in-service bit left", r, 8'h00);
    irq_in[7] = 1'b1; settle();
    check("R10 next request not blocked", {7'b0, int_out}, 8'h01);

    // single, no mode word
    wr(1'b0, 8'h12);
    rd(1'b0, r); check("R2 init clears pending", r, 8'h00);
    check("R2 int_out low after init", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h0F);
    rd(1'b1, r); check("R12 write after base is mask", r, 8'h0F);
    irq_in = '0; settle();
    irq_in[4] = 1'b1; settle();
    ack("R12 vector with new base", 8'h84);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R12 normal EOI holds bit", r, 8'h10);

    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R7 missing vectors: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_test();
  end
endmodule